// File: doc/BRIEF.md
# Fixed-Length Framed Streaming Multiply-Accumulator

This block takes a stream of signed scalar pairs, one pair per clock, and adds up their products over frames of a fixed number of samples. A sample is taken only on cycles where the input qualifier is high. The frame length is a build-time parameter, so no start or end strobes are needed. An internal sample counter marks where each frame begins and ends. The counter is visible on an index output that runs from 1 to the frame length.

All outputs are registered. Each accepted sample shows up one cycle later on the data output as the running sum. The output qualifier, the position index and the last-sample flag appear in that same cycle. On the last sample of a frame the block raises the last-sample flag, then clears its sum and index. The next accepted sample opens a fresh frame. Idle cycles inside a frame freeze the outputs. Idle cycles outside a frame show a zero sum and an index of 1.

Top module: `smac_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `data_out` = 0, `count_out` = 1, `valid_out` = 0 and `end_out` = 0. The open frame is discarded.
- R2: When no frame is open (after reset, or once a frame has ended) and `valid_in` is low, the next cycle shows `data_out` = 0 and `count_out` = 1.
- R3: `valid_out` equals `valid_in` delayed by exactly one clock.
- R4: On a cycle after `valid_in` was high, `data_out` equals the two's-complement sum, modulo 2^ACC_W, of the signed products `a_in*b_in` of every accepted sample of the open frame, including the sample from the previous cycle.
- R5: On each output cycle with `valid_out` high, `count_out` is the 1-based position of that sample within its frame, increasing by 1 per accepted sample up to the frame length N.
- R6: When a frame is open and `valid_in` is low, `data_out` and `count_out` keep their previous values.
- R7: `end_out` is high for exactly the output cycle of the Nth sample of a frame, together with `valid_out` = 1 and `count_out` = N. It is low on every other cycle.
- R8: The sample accepted on the cycle after a frame's Nth sample, or at any later time, starts a new frame. Its sum does not include any earlier product and it shows `count_out` = 1.
- R9: A `FRAME_LEN` below 1 acts as 1: every accepted sample forms a frame of its own, with `count_out` = 1, `end_out` = 1 and `data_out` equal to that single product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DATA_W | First signed operand |
| b_in | input | DATA_W | Second signed operand |
| valid_in | input | 1 | Qualifies the operand pair for accumulation |
| data_out | output | ACC_W | Signed running frame sum |
| valid_out | output | 1 | data_out was updated by an accepted sample |
| end_out | output | 1 | Pulse with the last sample of a frame |
| count_out | output | CNT_W | Position of the sample in its frame, 1 to N |

## Verification
The bench drives two instances: a frame length of five, and a frame length of zero that must behave as one. Stimulus covers idle gaps inside a frame, back-to-back frames and a reset in the middle of a frame. A design that forgot to clear the sum at the frame boundary would carry the old total into the next frame. A design that cleared the sum on idle cycles would lose part of a frame that has gaps, and an off-by-one counter would move `end_out` to the wrong sample. Negative operands, including the most negative value, check that products are sign-extended before they are added.

// File: rtl/smac_pkg.sv
package smac_pkg;

  // Position of the next accepted sample inside the open frame.
  typedef struct packed {
    logic fresh;  // no sample of the current frame accepted yet
    logic last;   // next accepted sample closes the frame
  } frame_pos_t;

  // A frame length below one behaves as one.
  function automatic int eff_len(input int n);
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/smac_mult.sv
module smac_mult #(
  parameter int DATA_W = 8,
  parameter int PROD_W = 2 * DATA_W
) (
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [PROD_W-1:0] prod
);

  // Full-precision signed product, no rounding.
  always_comb prod = a * b;

endmodule

// File: rtl/smac_frame_ctr.sv
module smac_frame_ctr
  import smac_pkg::*;
#(
  parameter int N_EFF = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output frame_pos_t       pos,
  output logic [CNT_W-1:0] count_out,
  output logic             end_out
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_EFF - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  // Number of samples already taken in the open frame (0 .. N_EFF-1).
  logic [CNT_W-1:0] idx_q;

  generate
    if (N_EFF == 1) begin : g_single
      // Every sample closes its own frame: nothing to count.
      always_comb idx_q = '0;
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)
          idx_q <= '0;
        else if (adv)
          idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + ONE;
      end
    end
  endgenerate

  always_comb begin
    pos.fresh = (idx_q == '0);
    pos.last  = (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_out <= ONE;
      end_out   <= 1'b0;
    end else begin
      end_out <= adv && pos.last;
      if (adv)
        count_out <= idx_q + ONE;
      else if (pos.fresh)
        count_out <= ONE;
    end
  end

endmodule

// File: rtl/smac_accum.sv
module smac_accum
  import smac_pkg::*;
#(
  parameter int PROD_W = 16,
  parameter int ACC_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  frame_pos_t               pos,
  input  logic signed [PROD_W-1:0] prod,
  output logic signed [ACC_W-1:0]  data_out
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sum;

  // acc_q is zero whenever no frame is open, so no extra select is needed.
  always_comb sum = acc_q + ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      data_out <= '0;
    end else if (adv) begin
      data_out <= sum;
      acc_q    <= pos.last ? '0 : sum;
    end else if (pos.fresh) begin
      data_out <= '0;
    end
  end

endmodule

// File: rtl/smac_top.sv
module smac_top #(
  parameter int DATA_W    = 8,
  parameter int ACC_W     = 20,
  parameter int FRAME_LEN = 2,
  parameter int CNT_W     = $clog2(((FRAME_LEN < 1) ? 1 : FRAME_LEN) + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] a_in,
  input  logic signed [DATA_W-1:0] b_in,
  input  logic                     valid_in,
  output logic signed [ACC_W-1:0]  data_out,
  output logic                     valid_out,
  output logic                     end_out,
  output logic [CNT_W-1:0]         count_out
);

  localparam int N_EFF  = smac_pkg::eff_len(FRAME_LEN);
  localparam int PROD_W = 2 * DATA_W;

  smac_pkg::frame_pos_t    pos;
  logic signed [PROD_W-1:0] prod;

  smac_mult #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_mult (
    .a(a_in), .b(b_in), .prod(prod)
  );

  smac_frame_ctr #(.N_EFF(N_EFF), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .adv(valid_in), .pos(pos),
    .count_out(count_out), .end_out(end_out)
  );

  smac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .adv(valid_in), .pos(pos),
    .prod(prod), .data_out(data_out)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_out <= 1'b0;
    else     valid_out <= valid_in;
  end

endmodule

// File: rtl/smac_checker.sv
module smac_checker #(
  parameter int N_EFF = 2,
  parameter int ACC_W = 20,
  parameter int CNT_W = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    valid_in,
  input logic signed [ACC_W-1:0] data_out,
  input logic                    valid_out,
  input logic                    end_out,
  input logic [CNT_W-1:0]        count_out
);

  localparam logic [CNT_W-1:0] N_CNT = CNT_W'(N_EFF);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs one cycle after reset
  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_state_R1: assert (count_out == ONE && data_out == '0 &&
                                     !valid_out && !end_out)
        else $error("reset state wrong");
    end
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (end_out && !valid_in) |=> (data_out == '0 && count_out == ONE));

  assert_valid_follow_R3: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  assert_valid_drop_R3: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  assert_count_range_R5: assert property (@(posedge clk) disable iff (rst)
    (count_out >= ONE && count_out <= N_CNT));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_in && valid_out && !end_out) |=> (count_out == $past(count_out) + ONE));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!valid_in && !end_out && count_out != ONE) |=> ($stable(data_out) && $stable(count_out)));

  assert_end_last_R7: assert property (@(posedge clk) disable iff (rst)
    end_out |-> (valid_out && count_out == N_CNT));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (end_out && valid_in) |=> (count_out == ONE));

endmodule

bind smac_top smac_checker #(.N_EFF(N_EFF), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .data_out(data_out),
  .valid_out(valid_out), .end_out(end_out), .count_out(count_out)
);

// File: tb/tb_smac_top.sv
module tb_smac_top;

  localparam int DW = 8;
  localparam int AW = 20;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DW-1:0] a = '0;
  logic signed [DW-1:0] b = '0;
  logic valid_in = 1'b0;

  logic signed [AW-1:0] d0, d1;
  logic v0, v1, e0, e1;
  logic [2:0] c0;
  logic [0:0] c1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smac_top #(.DATA_W(DW), .ACC_W(AW), .FRAME_LEN(5)) dut (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .valid_in(valid_in),
    .data_out(d0), .valid_out(v0), .end_out(e0), .count_out(c0)
  );

  smac_top #(.DATA_W(DW), .ACC_W(AW), .FRAME_LEN(0)) dut1 (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .valid_in(valid_in),
    .data_out(d1), .valid_out(v1), .end_out(e1), .count_out(c1)
  );

  // Reference state per instance: 0 -> length 5, 1 -> length 0 (acts as 1)
  int     n_len [2] = '{5, 1};
  longint m_acc [2];
  int     m_taken [2];
  longint x_data [2];
  int     x_cnt [2];
  bit     x_v [2];
  bit     x_e [2];
  string  tag_d [2];
  string  tag_c [2];

  function automatic longint wrap(input longint x);
    return (x <<< (64 - AW)) >>> (64 - AW);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input bit r, input bit v, input longint p);
    for (int k = 0; k < 2; k++) begin
      if (r) begin
        m_acc[k] = 0; m_taken[k] = 0;
        x_data[k] = 0; x_cnt[k] = 1; x_v[k] = 0; x_e[k] = 0;
        tag_d[k] = "R1"; tag_c[k] = "R1";
      end else if (v) begin
        tag_d[k] = (m_taken[k] == 0) ? "R8" : "R4";
        tag_c[k] = (m_taken[k] == 0) ? "R8" : "R5";
        m_acc[k] = wrap(m_acc[k] + p);
        x_data[k] = m_acc[k];
        m_taken[k]++;
        x_cnt[k] = m_taken[k];
        x_v[k] = 1;
        x_e[k] = (m_taken[k] == n_len[k]);
        if (x_e[k]) begin
          m_acc[k] = 0; m_taken[k] = 0;
        end
      end else begin
        x_v[k] = 0; x_e[k] = 0;
        if (m_taken[k] == 0) begin
          x_data[k] = 0; x_cnt[k] = 1;
          tag_d[k] = "R2"; tag_c[k] = "R2";
        end else begin
          tag_d[k] = "R6"; tag_c[k] = "R6";
        end
      end
      if (k == 1) begin
        tag_d[k] = "R9"; tag_c[k] = "R9";
      end
    end
  endtask

  task automatic compare();
    longint ad [2];
    longint ac [2];
    bit av [2];
    bit ae [2];
    ad[0] = longint'(d0); ad[1] = longint'(d1);
    ac[0] = longint'(c0); ac[1] = longint'(c1);
    av[0] = v0; av[1] = v1; ae[0] = e0; ae[1] = e1;
    for (int k = 0; k < 2; k++) begin
      check(ad[k] == x_data[k], tag_d[k], "data_out", ad[k], x_data[k]);
      check(ac[k] == longint'(x_cnt[k]), tag_c[k], "count_out", ac[k], x_cnt[k]);
      check(av[k] == x_v[k], (k == 1) ? "R9" : "R3", "valid_out", av[k], x_v[k]);
      check(ae[k] == x_e[k], (k == 1) ? "R9" : "R7", "end_out", ae[k], x_e[k]);
    end
  endtask

  // Inputs change at the falling edge; the model steps at the rising edge;
  // outputs are compared at the next falling edge.
  task automatic tick(input bit r, input bit v,
                      input logic signed [DW-1:0] aa, input logic signed [DW-1:0] bb);
    rst = r; valid_in = v; a = aa; b = bb;
    @(posedge clk);
    #1;
    model_step(r, v, longint'(aa) * longint'(bb));
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    // R1: reset
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 8'sd0, 8'sd0);
    // R2: idle before any frame
    for (int i = 0; i < 2; i++) tick(1'b0, 1'b0, 8'sd9, 8'sd9);
    // R4 R5 R7: one continuous frame with negative operands
    tick(1'b0, 1'b1, 8'sd3, 8'sd4);
    tick(1'b0, 1'b1, -8'sd2, 8'sd5);
    tick(1'b0, 1'b1, 8'sd7, 8'sd7);
    tick(1'b0, 1'b1, -8'sd128, 8'sd1);
    tick(1'b0, 1'b1, 8'sd1, -8'sd1);
    // R2: idle after frame end
    tick(1'b0, 1'b0, 8'sd5, 8'sd5);
    tick(1'b0, 1'b0, 8'sd5, 8'sd5);
    // R6: frame with idle gaps
    tick(1'b0, 1'b1, 8'sd10, 8'sd10);
    tick(1'b0, 1'b0, 8'sd50, 8'sd50);
    tick(1'b0, 1'b0, 8'sd50, 8'sd50);
    tick(1'b0, 1'b1, -8'sd128, -8'sd128);
    tick(1'b0, 1'b0, 8'sd1, 8'sd1);
    tick(1'b0, 1'b1, 8'sd2, 8'sd3);
    tick(1'b0, 1'b1, 8'sd4, 8'sd5);
    tick(1'b0, 1'b0, 8'sd1, 8'sd1);
    tick(1'b0, 1'b1, 8'sd6, 8'sd7);
    // R8: back-to-back frames
    for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, 8'(i + 1), 8'(2 * i - 5));
    // R1: reset in the middle of the open frame, then a fresh frame
    tick(1'b1, 1'b1, 8'sd9, 8'sd9);
    tick(1'b0, 1'b1, 8'sd2, 8'sd2);
    tick(1'b0, 1'b0, 8'sd0, 8'sd0);
    // mixed stream
    for (int i = 0; i < 400; i++)
      tick(1'b0, ($urandom % 10) < 6, 8'($urandom), 8'($urandom));
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 8'sd0, 8'sd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule